// File: doc/BRIEF.md
# Read/Write Mix Arbiter Selector

This block sits beside a memory controller's reorder queues. The controller has three history-based command arbiters. Each arbiter is tuned for a different balance of reads and writes. The block watches one pulse for each read command that arrives and one pulse for each write command that arrives. It counts both pulses over a fixed window of clock cycles. When the window closes, it decides which arbiter best matches the measured mix. It then drives a 2-bit code to the multiplexer in front of the arbiters. The goal is for the issue ratio of the selected arbiter to follow the ratio in which the workload produces reads and writes.

The decision is a three-state machine: `MIX_RD_HEAVY`, `MIX_BALANCED` and `MIX_WR_HEAVY`.
- The state can move only on the last cycle of a window.
- At that point a ratio judge gives one of four verdicts: read-heavy, balanced, write-heavy, or hold. Hold means the window saw no commands.
- The transitions are named `T_TO_RD`, `T_TO_BAL`, `T_TO_WR` and `T_STAY`.
- `T_STAY` is taken on a hold verdict, on a verdict that equals the current state, and on every cycle that is not a window end.
- `T_TO_RD`, `T_TO_BAL` and `T_TO_WR` go from any state to the named state.

A strobe marks, for one cycle, each window end at which the code changed.

Top module: `mix_selector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `arb_sel` is 2'b01 (balanced arbiter) and `sel_switch` is 0. The cycle counter and both command counters restart from zero, so the first window covers exactly `WINDOW_CYCLES` clock edges after reset release.
- R2: The `arb_sel` encoding is 2'b00 for the two-reads-per-write arbiter, 2'b01 for one read per write, and 2'b10 for one read per two writes. The code 2'b11 never appears.
- R3: At a window end with at least one command, the block selects 2'b00 when 2*reads >= 3*writes. The boundary case of reads equal to exactly 1.5 times writes counts as read-heavy.
- R4: At a window end with at least one command, the block selects 2'b10 when 2*writes >= 3*reads.
- R5: At a window end with at least one command where neither R3 nor R4 holds, the block selects 2'b01.
- R6: A window in which no read or write pulse arrived leaves `arb_sel` unchanged and raises no strobe.
- R7: `arb_sel` changes only on the clock edge that closes a window. `sel_switch` is high for exactly the one cycle after that edge when the code changed, and it is low otherwise.
- R8: The counts are taken over the whole window, including pulses in its last cycle. A read and a write in the same cycle each count. Both counters clear at every window end, so no count carries into the next window.
- R9: The read and write counters saturate at 2^CNT_W-1 rather than wrapping. The judgement then uses the saturated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_arrive | input | 1 | One-cycle pulse per read command arrival |
| wr_arrive | input | 1 | One-cycle pulse per write command arrival |
| arb_sel | output | 2 | Selected arbiter code (see R2) |
| sel_switch | output | 1 | One-cycle strobe when `arb_sel` changed at a window end |

## Verification
The bench drives the read/write mix at the exact 1.5:1 boundary and one read below it. A comparison that used a strict inequality, or swapped the factors 2 and 3, would pick the wrong arbiter there.

It follows a read-flooded window with a write-leaning one. A design that failed to clear its counters at the window end would stay read-heavy.

It sends more reads than the counter range. The selection then shows balanced when the counters saturate and write-heavy when they wrap.

It also runs an empty window and probes mid-window. A design that treated zero counts as read-heavy, or that moved the code before the window closed, would show a change or a strobe that should not be there.

// File: rtl/mixsel_pkg.sv
package mixsel_pkg;

    // Arbiter code; the values are what the output multiplexer decodes.
    typedef enum logic [1:0] {
        MIX_RD_HEAVY = 2'b00,
        MIX_BALANCED = 2'b01,
        MIX_WR_HEAVY = 2'b10
    } mix_t;

    typedef enum logic [1:0] {
        VERDICT_HOLD = 2'b00,
        VERDICT_RD   = 2'b01,
        VERDICT_BAL  = 2'b10,
        VERDICT_WR   = 2'b11
    } verdict_t;

endpackage

// File: rtl/mixsel_window_timer.sv
module mixsel_window_timer #(
    parameter int WINDOW_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_last
);
    localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [WIN_W-1:0] LAST_IDX = WIN_W'(WINDOW_CYCLES - 1);

    logic [WIN_W-1:0] cyc_q;

    assign win_last = (cyc_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (win_last) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/mixsel_sat_counter.sv
module mixsel_sat_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clear,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // total includes the current cycle's pulse so a window's last cycle counts
    always_comb begin
        if (inc && (cnt_q != CNT_MAX)) begin
            total = cnt_q + 1'b1;
        end else begin
            total = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= total;
        end
    end
endmodule

// File: rtl/mixsel_ratio_judge.sv
module mixsel_ratio_judge
    import mixsel_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] rd_total,
    input  logic [CNT_W-1:0] wr_total,
    output verdict_t         verdict
);
    localparam int PW = CNT_W + 2;

    logic [PW-1:0] rd_x2, rd_x3, wr_x2, wr_x3;

    always_comb begin
        rd_x2 = PW'(rd_total) << 1;
        wr_x2 = PW'(wr_total) << 1;
        rd_x3 = rd_x2 + PW'(rd_total);
        wr_x3 = wr_x2 + PW'(wr_total);

        if ((rd_total == '0) && (wr_total == '0)) begin
            verdict = VERDICT_HOLD;
        end else if (rd_x2 >= wr_x3) begin
            verdict = VERDICT_RD;
        end else if (wr_x2 >= rd_x3) begin
            verdict = VERDICT_WR;
        end else begin
            verdict = VERDICT_BAL;
        end
    end
endmodule

// File: rtl/mix_selector.sv
module mix_selector
    import mixsel_pkg::*;
#(
    parameter int WINDOW_CYCLES = 1024,
    parameter int CNT_W         = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_arrive,
    input  logic       wr_arrive,
    output logic [1:0] arb_sel,
    output logic       sel_switch
);
    localparam int NUM_CH = 2;   // channel 0 = reads, channel 1 = writes

    logic                 win_last;
    logic [NUM_CH-1:0]    arrive_vec;
    logic [CNT_W-1:0]     ch_total [NUM_CH];
    verdict_t             verdict;
    mix_t                 state_q, state_d;
    logic                 switch_q;

    assign arrive_vec = {wr_arrive, rd_arrive};

    mixsel_window_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_last (win_last)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_count
        mixsel_sat_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (arrive_vec[ch]),
            .clear (win_last),
            .total (ch_total[ch])
        );
    end

    mixsel_ratio_judge #(
        .CNT_W(CNT_W)
    ) u_judge (
        .rd_total (ch_total[0]),
        .wr_total (ch_total[1]),
        .verdict  (verdict)
    );

    // next-state: transitions only on the window's last cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MIX_RD_HEAVY, MIX_BALANCED, MIX_WR_HEAVY: begin
                if (win_last) begin
                    unique case (verdict)
                        VERDICT_RD:   state_d = MIX_RD_HEAVY;  // T_TO_RD
                        VERDICT_BAL:  state_d = MIX_BALANCED;  // T_TO_BAL
                        VERDICT_WR:   state_d = MIX_WR_HEAVY;  // T_TO_WR
                        VERDICT_HOLD: state_d = state_q;       // T_STAY
                        default:      state_d = state_q;
                    endcase
                end
            end
            default: state_d = MIX_BALANCED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MIX_BALANCED;
        end else begin
            state_q <= state_d;
        end
    end

    // output register: strobe on a real change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            switch_q <= 1'b0;
        end else begin
            switch_q <= win_last && (state_d != state_q);
        end
    end

    assign arb_sel    = state_q;
    assign sel_switch = switch_q;
endmodule

// File: rtl/mixsel_checker.sv
module mixsel_checker #(
    parameter int WINDOW_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_arrive,
    input logic       wr_arrive,
    input logic [1:0] arb_sel,
    input logic       sel_switch
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1) + 1;

    logic [CW-1:0] pos_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            seen_q <= 1'b0;
        end else if (pos_q == CW'(WINDOW_CYCLES - 1)) begin
            pos_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            pos_q  <= pos_q + 1'b1;
            seen_q <= seen_q | rd_arrive | wr_arrive;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (arb_sel == 2'b01 && !sel_switch));

    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        arb_sel != 2'b11);

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        sel_switch |=> !sel_switch);

    a_r7_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(arb_sel) |-> sel_switch);

    a_r7_strobe_has_change: assert property (@(posedge clk) disable iff (!rst_n)
        sel_switch |-> !$stable(arb_sel));

    a_r7_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        sel_switch |-> (pos_q == '0));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == CW'(WINDOW_CYCLES - 1) && !seen_q && !rd_arrive && !wr_arrive)
        |=> (!sel_switch && $stable(arb_sel)));
endmodule

bind mix_selector mixsel_checker #(
    .WINDOW_CYCLES(WINDOW_CYCLES)
) u_mixsel_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_arrive  (rd_arrive),
    .wr_arrive  (wr_arrive),
    .arb_sel    (arb_sel),
    .sel_switch (sel_switch)
);

// File: tb/test_mix_selector.sv
`timescale 1ns/1ps
module test_mix_selector;
    localparam int W   = 32;
    localparam int CW  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_arrive = 1'b0;
    logic       wr_arrive = 1'b0;
    logic [1:0] arb_sel;
    logic       sel_switch;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    mix_selector #(
        .WINDOW_CYCLES(W),
        .CNT_W(CW)
    ) i_mix_selector (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_arrive  (rd_arrive),
        .wr_arrive  (wr_arrive),
        .arb_sel    (arb_sel),
        .sel_switch (sel_switch)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One full window: reads in the first nr cycles, writes in the first nw.
    // Called just after a negedge at the start of a window.
    task automatic run_window(input int nr, input int nw, input logic [1:0] exp_sel,
                              input logic exp_sw, input string req);
        logic [1:0] start_sel;
        start_sel = arb_sel;
        for (int i = 0; i < W; i++) begin
            rd_arrive = (i < nr);
            wr_arrive = (i < nw);
            @(negedge clk);
            if (i == W / 2) begin
                check(sel_switch == 1'b0, "R7", "mid-window strobe", sel_switch, 0);
                check(arb_sel == start_sel, "R7", "mid-window sel", arb_sel, start_sel);
            end
        end
        rd_arrive = 1'b0;
        wr_arrive = 1'b0;
        check(arb_sel == exp_sel, req, "window-end sel", arb_sel, exp_sel);
        check(sel_switch == exp_sw, req, "window-end strobe", sel_switch, exp_sw);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(arb_sel == 2'b01, "R1", "sel in reset", arb_sel, 1);
        check(sel_switch == 1'b0, "R1", "strobe in reset", sel_switch, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_read_heavy;
        run_window(8, 4, 2'b00, 1'b1, "R3");   // 16 >= 12
        run_window(8, 4, 2'b00, 1'b0, "R7");   // same mix, no strobe
    endtask

    task automatic t_idle;
        run_window(0, 0, 2'b00, 1'b0, "R6");
    endtask

    task automatic t_balanced_and_boundary;
        run_window(6, 5, 2'b01, 1'b1, "R5");   // 12<15, 10<18
        run_window(5, 4, 2'b01, 1'b0, "R5");   // 10<12: just below
        run_window(6, 4, 2'b00, 1'b1, "R3");   // 12>=12: exact boundary
    endtask

    task automatic t_write_heavy;
        run_window(4, 6, 2'b10, 1'b1, "R4");   // 12>=12
        run_window(0, 3, 2'b10, 1'b0, "R4");
        run_window(0, 0, 2'b10, 1'b0, "R6");
    endtask

    task automatic t_clear;
        run_window(10, 0, 2'b00, 1'b1, "R8");
        run_window(2, 3, 2'b10, 1'b1, "R8");   // 6>=6 only if cleared
    endtask

    task automatic t_saturate;
        // 20 reads saturate at 15: 30<36 and 24<45 -> balanced; wrap gives 4 -> write-heavy
        run_window(20, 12, 2'b01, 1'b1, "R9");
    endtask

    task automatic t_legal;
        check(arb_sel != 2'b11, "R2", "code legal", arb_sel, 1);
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        check(arb_sel == 2'b01 && sel_switch == 1'b0, "R1", "after release",
              {sel_switch, arb_sel}, 1);
        // first window already had one cycle; finish it empty to realign
        for (int i = 1; i < W; i++) @(negedge clk);
        t_read_heavy();
        t_idle();
        t_balanced_and_boundary();
        t_write_heavy();
        t_clear();
        t_saturate();
        t_legal();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule